// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block sits behind an Ethernet receive MAC and stores every received frame in one circular byte buffer held in an external memory with a 32-bit synchronous write port. Each frame is placed behind a 32-bit status header on a 4-byte boundary. Frame bytes, including the trailing 4 CRC bytes, follow the header directly, and a frame that runs past the end of the buffer continues at offset 0. While a frame is still arriving, its header carries a fixed busy length. The real length and status replace the busy value only in the cycle the frame is committed.

Software drains the buffer through a consumer register. The value it writes sits 16 bytes behind the true read position, so the block adds 16 modulo the buffer size to find where the consumer really is. The current write offset shows software how far valid data extends, and an empty flag is raised whenever the consumer position and the write offset are equal. A frame that would run into unread data is discarded as a whole. A missed-frame counter is then incremented and the write offset stays at the start of the discarded frame.

The input stream carries one byte per cycle with first and last markers, plus CRC-error and alignment-error flags that are sampled with the last byte. At least one idle cycle must follow each last byte before the next first byte.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the write offset is 0, the consumer register reads BUF_BYTES-16, the empty flag is 1, the missed-frame count is 0 and no memory write is issued.
- R2: A stored frame's header word has its length (all bytes received, CRC included) in bits 31:16. Body byte k of the frame lands at buffer offset header+4+k, in byte lane (k mod 4) of its 32-bit word, with lane i on data bits 8i+7:8i.
- R3: When a frame of two or more bytes starts, its header word is first written with 0xFFF0 in bits 31:16 and 0 in bits 15:0. The final length and status overwrite it only after the last byte.
- R4: On commit the write offset becomes (header + 4 + length rounded up to a multiple of 4) mod BUF_BYTES. It is always a multiple of 4, and it changes only in the cycle the final header write is on the memory port.
- R5: Body bytes that pass the end of the buffer continue at offset 0.
- R6: Status bits in the header: bit 0 receive-OK, bit 1 alignment error, bit 2 CRC error, bit 4 short frame (length below MIN_LEN). Receive-OK is 1 exactly when none of the other three is set. Short or errored frames are still stored.
- R7: The consumer register reads back the last value written. The true consumer position is that value plus 16, modulo BUF_BYTES.
- R8: The empty flag is 1 exactly when the true consumer position equals the write offset.
- R9: Let free = (consumer - header) mod BUF_BYTES, taken as BUF_BYTES when this is 0. A frame needing 4 + roundup4(length) bytes is dropped when that need is not below free. A dropped frame adds 1 to the missed-frame count (saturating), leaves the write offset unchanged and commits no header.
- R10: At most one memory write is issued per cycle. Its byte enables are always 0001, 0011, 0111 or 1111. A body word is written when lane 3 fills or when the last byte arrives.
- R11: A one-byte frame (first and last in the same cycle) is stored with length 1 and the short-frame status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received byte is present |
| in_byte | input | 8 | Received byte |
| in_first | input | 1 | Byte is the first of its frame |
| in_last | input | 1 | Byte is the last of its frame |
| in_crc_bad | input | 1 | CRC check failed (sampled with last byte) |
| in_align_bad | input | 1 | Alignment error (sampled with last byte) |
| cons_we | input | 1 | Write strobe for the consumer register |
| cons_wdata | input | 16 | New consumer register value |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | $clog2(BUF_BYTES)-2 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte enables |
| wr_ofs | output | 16 | Current write offset (end of valid data) |
| cons_ptr | output | 16 | Consumer register readback |
| buf_empty | output | 1 | Consumer position equals write offset |
| miss_cnt | output | MISS_W | Count of dropped frames |

## Verification
A consumer-register write from software can land in the same cycle as the commit of a frame's final header. The empty flag then has to reflect both the new write offset and the new consumer position at once. The bench provokes this by driving the consumer write one cycle after a frame's last byte, with the value that makes the consumer equal to the committed offset. It then requires the empty flag to be 1 on the following sample and the header and body of that frame to be intact. The free-space check uses the consumer value held before that write, so the frame's fit is judged against the old position.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BODY  = 2'd1,
        ST_FINAL = 2'd2
    } rxr_state_e;

    // Length value shown in a header while its frame is still arriving
    localparam logic [15:0] LEN_BUSY = 16'hFFF0;

    // Status bit positions in the low half of the header
    localparam int STAT_OK    = 0;
    localparam int STAT_ALIGN = 1;
    localparam int STAT_CRC   = 2;
    localparam int STAT_SHORT = 4;

    // Byte distance between the consumer register and the true read position
    localparam int CONS_SKEW = 16;

endpackage

// File: rtl/rxr_space.sv
module rxr_space
    import rxr_pkg::*;
#(
    parameter int BUF_BYTES = 8192,
    parameter int OFS_W     = 13
) (
    input  logic [OFS_W-1:0] base,
    input  logic [OFS_W-1:0] cons_reg,
    input  logic [15:0]      count,
    output logic [OFS_W-1:0] cons_pos,
    output logic             fits
);
    localparam logic [16:0] BUF_FULL = 17'(BUF_BYTES);

    logic [OFS_W-1:0] gap;
    logic [16:0]      free_b;
    logic [16:0]      need_b;

    always_comb begin
        cons_pos = cons_reg + OFS_W'(CONS_SKEW);
        gap      = cons_pos - base;
        free_b   = (gap == '0) ? BUF_FULL : 17'(gap);
        need_b   = (({1'b0, count} + 17'd3) & ~17'd3) + 17'd4;
        fits     = (need_b < free_b);
    end
endmodule

// File: rtl/rxr_hdr.sv
module rxr_hdr
    import rxr_pkg::*;
#(
    parameter int MIN_LEN = 64
) (
    input  logic [15:0] len,
    input  logic        crc_bad,
    input  logic        align_bad,
    output logic [15:0] stat
);
    logic short_f;

    always_comb begin
        short_f               = (len < 16'(MIN_LEN));
        stat                  = '0;
        stat[STAT_ALIGN]      = align_bad;
        stat[STAT_CRC]        = crc_bad;
        stat[STAT_SHORT]      = short_f;
        stat[STAT_OK]         = ~(short_f | crc_bad | align_bad);
    end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int BUF_BYTES = 8192,
    parameter int MISS_W    = 16,
    parameter int MIN_LEN   = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [7:0]                    in_byte,
    input  logic                          in_first,
    input  logic                          in_last,
    input  logic                          in_crc_bad,
    input  logic                          in_align_bad,
    input  logic                          cons_we,
    input  logic [15:0]                   cons_wdata,
    output logic                          mem_we,
    output logic [$clog2(BUF_BYTES)-3:0]  mem_addr,
    output logic [31:0]                   mem_wdata,
    output logic [3:0]                    mem_be,
    output logic [15:0]                   wr_ofs,
    output logic [15:0]                   cons_ptr,
    output logic                          buf_empty,
    output logic [MISS_W-1:0]             miss_cnt
);
    localparam int OFS_W = $clog2(BUF_BYTES);
    localparam int AW    = OFS_W - 2;
    localparam logic [MISS_W-1:0] MISS_MAX = '1;

    typedef struct packed {
        rxr_state_e        st;
        logic [OFS_W-1:0]  base;
        logic [15:0]       cnt;
        logic [31:0]       acc;
        logic              drop;
        logic              crc;
        logic              align;
        logic [OFS_W-1:0]  wr;
        logic [15:0]       cons;
        logic [MISS_W-1:0] miss;
        logic              we;
        logic [AW-1:0]     addr;
        logic [31:0]       data;
        logic [3:0]        be;
    } regs_t;

    regs_t q, d;

    // Frame-relative values shared by the next-state logic
    logic [OFS_W-1:0] frame_base;
    logic [15:0]      cnt_cur;
    logic [15:0]      cnt_nx;
    logic [1:0]       lane;
    logic [31:0]      acc_mix;
    logic [3:0]       be_fill;
    logic [OFS_W-1:0] body_ofs;
    logic [OFS_W-1:0] cnt_lo;
    logic [OFS_W-1:0] commit_ofs;
    logic [OFS_W-1:0] cons_pos;
    logic             room;
    logic [15:0]      stat_w;

    assign frame_base = (q.st == ST_IDLE) ? q.wr : q.base;
    assign cnt_cur    = (q.st == ST_IDLE) ? 16'd0 : q.cnt;
    assign cnt_nx     = cnt_cur + 16'd1;
    assign lane       = cnt_cur[1:0];
    assign body_ofs   = frame_base + OFS_W'(4) + cnt_cur[OFS_W-1:0];
    assign cnt_lo     = q.cnt[OFS_W-1:0];
    assign commit_ofs = q.base + OFS_W'(4) + ((cnt_lo + OFS_W'(3)) & ~OFS_W'(3));

    // Byte-lane merge and contiguous enable mask, one slice per lane
    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign acc_mix[8*g +: 8] = (lane == 2'(g)) ? in_byte :
                                   ((lane == 2'd0) ? 8'h00 : q.acc[8*g +: 8]);
        assign be_fill[g]        = (2'(g) <= lane);
    end

    rxr_space #(
        .BUF_BYTES (BUF_BYTES),
        .OFS_W     (OFS_W)
    ) u_space (
        .base     (frame_base),
        .cons_reg (q.cons[OFS_W-1:0]),
        .count    (cnt_nx),
        .cons_pos (cons_pos),
        .fits     (room)
    );

    rxr_hdr #(
        .MIN_LEN (MIN_LEN)
    ) u_hdr (
        .len       (q.cnt),
        .crc_bad   (q.crc),
        .align_bad (q.align),
        .stat      (stat_w)
    );

    always_comb begin
        d    = q;
        d.we = 1'b0;

        if (cons_we) begin
            d.cons = cons_wdata;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (in_valid && in_first) begin
                    d.base  = q.wr;
                    d.cnt   = cnt_nx;
                    d.acc   = acc_mix;
                    d.drop  = ~room;
                    d.crc   = in_crc_bad;
                    d.align = in_align_bad;
                    if (in_last) begin
                        d.st = ST_FINAL;
                        if (room) begin
                            d.we   = 1'b1;
                            d.addr = body_ofs[OFS_W-1:2];
                            d.data = acc_mix;
                            d.be   = be_fill;
                        end
                    end else begin
                        d.st = ST_BODY;
                        if (room) begin
                            d.we   = 1'b1;
                            d.addr = q.wr[OFS_W-1:2];
                            d.data = {LEN_BUSY, 16'h0000};
                            d.be   = 4'hF;
                        end
                    end
                end
            end

            ST_BODY: begin
                if (in_valid) begin
                    d.cnt  = cnt_nx;
                    d.acc  = acc_mix;
                    d.drop = q.drop | ~room;
                    if (!d.drop && ((lane == 2'd3) || in_last)) begin
                        d.we   = 1'b1;
                        d.addr = body_ofs[OFS_W-1:2];
                        d.data = acc_mix;
                        d.be   = be_fill;
                    end
                    if (in_last) begin
                        d.crc   = in_crc_bad;
                        d.align = in_align_bad;
                        d.st    = ST_FINAL;
                    end
                end
            end

            ST_FINAL: begin
                d.st = ST_IDLE;
                if (q.drop) begin
                    if (q.miss != MISS_MAX) begin
                        d.miss = q.miss + MISS_W'(1);
                    end
                end else begin
                    d.we   = 1'b1;
                    d.addr = q.base[OFS_W-1:2];
                    d.data = {q.cnt, stat_w};
                    d.be   = 4'hF;
                    d.wr   = commit_ofs;
                end
            end

            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.cons <= 16'(BUF_BYTES - CONS_SKEW);
        end else begin
            q <= d;
        end
    end

    assign mem_we    = q.we;
    assign mem_addr  = q.addr;
    assign mem_wdata = q.data;
    assign mem_be    = q.be;
    assign wr_ofs    = 16'(q.wr);
    assign cons_ptr  = q.cons;
    assign buf_empty = (cons_pos == q.wr);
    assign miss_cnt  = q.miss;

endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
    parameter int BUF_BYTES = 8192,
    parameter int MISS_W    = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic [3:0]        mem_be,
    input logic [31:0]       mem_wdata,
    input logic [15:0]       wr_ofs,
    input logic [MISS_W-1:0] miss_cnt
);
    // R4: write offset is word aligned and inside the buffer
    a_r4_wr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ofs[1:0] == 2'b00) && (32'(wr_ofs) < BUF_BYTES));

    // R4: the offset only moves together with a final header write
    a_r4_commit_with_hdr: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_ofs) |-> (mem_we && mem_be == 4'hF && mem_wdata[31:16] != 16'hFFF0));

    // R9: a drop leaves the write offset where it was
    a_r9_drop_rollback: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miss_cnt) |-> $stable(wr_ofs));

    // R9: the miss counter never goes backwards
    a_r9_miss_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        miss_cnt >= $past(miss_cnt));

    // R10: byte enables are non-empty and contiguous from lane 0
    a_r10_be_contig: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_be == 4'h1 || mem_be == 4'h3 || mem_be == 4'h7 || mem_be == 4'hF));
endmodule

bind rx_ring_writer rx_ring_writer_chk #(
    .BUF_BYTES (BUF_BYTES),
    .MISS_W    (MISS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .wr_ofs    (wr_ofs),
    .miss_cnt  (miss_cnt)
);

// File: tb/rx_ring_writer_tb_top.sv
`timescale 1ns/1ps
module rx_ring_writer_tb_top;
    localparam int L      = 256;
    localparam int MISS_W = 16;
    localparam int AW     = $clog2(L) - 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
    logic in_crc_bad = 1'b0, in_align_bad = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic cons_we = 1'b0;
    logic [15:0] cons_wdata = 16'h0000;
    logic mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0] mem_be;
    logic [15:0] wr_ofs, cons_ptr;
    logic buf_empty;
    logic [MISS_W-1:0] miss_cnt;

    always #2.5 clk = ~clk;

    rx_ring_writer #(.BUF_BYTES(L), .MISS_W(MISS_W), .MIN_LEN(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_first(in_first), .in_last(in_last), .in_crc_bad(in_crc_bad),
        .in_align_bad(in_align_bad), .cons_we(cons_we), .cons_wdata(cons_wdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .wr_ofs(wr_ofs), .cons_ptr(cons_ptr), .buf_empty(buf_empty), .miss_cnt(miss_cnt)
    );

    // Memory model: synchronous byte-enabled write port
    logic [31:0] mem [0:L/4-1];
    always @(posedge clk) begin
        if (mem_we) begin
            for (int b = 0; b < 4; b++) begin
                if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
            end
        end
    end

    int checks = 0;
    int errors = 0;
    int bad_be = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // R10 observation of the write port
    always @(negedge clk) begin
        if (rst_n && mem_we &&
            !(mem_be == 4'h1 || mem_be == 4'h3 || mem_be == 4'h7 || mem_be == 4'hF))
            bad_be++;
    end

    typedef struct {
        int  start;
        int  len;
        int  stat;
        bit  dropped;
        int  new_wr;
    } item_t;

    item_t sb[$];
    logic [7:0] shadow [0:L-1];
    int exp_wr = 0;
    int exp_cons = L - 16;

    task automatic set_cons(input int v);
        @(negedge clk);
        cons_we = 1'b1;
        cons_wdata = 16'(v);
        @(negedge clk);
        cons_we = 1'b0;
        exp_cons = v;
    endtask

    task automatic send_frame(input int len, input bit crc, input bit aln,
                              input int seed, input bit cons_final);
        int start, ct, gap, free, need, st;
        bit fits;
        item_t it;
        start = exp_wr;
        ct    = (exp_cons + 16) % L;
        gap   = (ct - start + L) % L;
        free  = (gap == 0) ? L : gap;
        need  = 4 + ((len + 3) / 4) * 4;
        fits  = need < free;
        st    = ((len < 64 || crc || aln) ? 0 : 1) | (aln << 1) | (crc << 2) | ((len < 64) << 4);
        it.start = start; it.len = len; it.stat = st; it.dropped = !fits;
        it.new_wr = fits ? (start + need) % L : start;
        if (fits) begin
            for (int i = 0; i < len; i++) shadow[(start + 4 + i) % L] = 8'(seed + i);
            exp_wr = it.new_wr;
        end
        sb.push_back(it);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i == 4 && fits) begin
                check(mem[start/4][31:16] == 16'hFFF0, "R3 busy header", int'(mem[start/4][31:16]), 32'hFFF0);
                check(int'(wr_ofs) == start, "R4 offset held mid-frame", int'(wr_ofs), start);
            end
            in_valid = 1'b1;
            in_byte = 8'(seed + i);
            in_first = (i == 0);
            in_last = (i == len - 1);
            in_crc_bad = (i == len - 1) ? crc : 1'b0;
            in_align_bad = (i == len - 1) ? aln : 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
        in_crc_bad = 1'b0; in_align_bad = 1'b0;
        if (cons_final) begin
            cons_we = 1'b1;
            cons_wdata = 16'((it.new_wr - 16 + L) % L);
            exp_cons = (it.new_wr - 16 + L) % L;
            @(negedge clk);
            cons_we = 1'b0;
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pops one expected item per commit or drop
    initial begin
        int mon_wr, mon_miss;
        item_t it;
        bit body_ok;
        int bad_at;
        mon_wr = 0; mon_miss = 0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (int'(wr_ofs) != mon_wr || int'(miss_cnt) != mon_miss) begin
                @(negedge clk);
                if (sb.size() == 0) begin
                    check(1'b0, "R4 unexpected commit", int'(wr_ofs), mon_wr);
                end else begin
                    it = sb.pop_front();
                    if (it.dropped) begin
                        check(int'(miss_cnt) == mon_miss + 1, "R9 miss count", int'(miss_cnt), mon_miss + 1);
                        check(int'(wr_ofs) == mon_wr, "R9 offset rolled back", int'(wr_ofs), mon_wr);
                    end else begin
                        check(int'(wr_ofs) == it.new_wr, "R4 committed offset", int'(wr_ofs), it.new_wr);
                        check(mem[it.start/4] == {16'(it.len), 16'(it.stat)}, "R2 R6 header word",
                              int'(mem[it.start/4]), (it.len << 16) | it.stat);
                        body_ok = 1'b1; bad_at = 0;
                        for (int k = 0; k < it.len; k++) begin
                            int o;
                            o = (it.start + 4 + k) % L;
                            if (mem[o/4][8*(o%4) +: 8] != shadow[o] && body_ok) begin
                                body_ok = 1'b0; bad_at = o;
                            end
                        end
                        check(body_ok, (it.start + 4 + it.len > L) ? "R5 wrapped body" : "R2 body bytes",
                              bad_at, 0);
                    end
                end
                mon_wr = int'(wr_ofs);
                mon_miss = int'(miss_cnt);
            end
        end
    end

    initial begin
        #(200000 * 5);
        check(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(wr_ofs == 16'd0, "R1 write offset", int'(wr_ofs), 0);
        check(int'(cons_ptr) == L - 16, "R1 consumer register", int'(cons_ptr), L - 16);
        check(buf_empty == 1'b1, "R1 empty flag", int'(buf_empty), 1);
        check(miss_cnt == '0 && !mem_we, "R1 misses and writes", int'(miss_cnt), 0);

        send_frame(64, 0, 0, 8'h10, 0);           // R2 R6 good frame
        send_frame(67, 1, 0, 8'h40, 0);           // R4 rounding, R6 CRC error
        check(buf_empty == 1'b0, "R8 not empty", int'(buf_empty), 0);
        set_cons((exp_wr - 16 + L) % L);
        @(negedge clk);
        check(int'(cons_ptr) == (exp_wr - 16 + L) % L, "R7 consumer readback", int'(cons_ptr), (exp_wr - 16 + L) % L);
        check(buf_empty == 1'b1, "R8 empty after drain", int'(buf_empty), 1);

        send_frame(20, 0, 1, 8'h80, 0);           // R6 short + alignment error
        send_frame(1, 0, 0, 8'hA5, 0);            // R11 one-byte frame
        set_cons((exp_wr - 16 + L) % L);
        send_frame(100, 0, 0, 8'h20, 0);          // R5 frame crossing the end
        check(int'(wr_ofs) == 20, "R5 offset after wrap", int'(wr_ofs), 20);

        send_frame(200, 0, 0, 8'h33, 0);          // R9 clearly too large
        send_frame(148, 0, 0, 8'h44, 0);          // R9 need equals free: dropped
        send_frame(144, 0, 0, 8'h55, 0);          // R9 need just below free: stored
        check(int'(miss_cnt) == 2, "R9 two drops", int'(miss_cnt), 2);
        check(buf_empty == 1'b0, "R8 nearly full not empty", int'(buf_empty), 0);

        set_cons((exp_wr - 16 + L) % L);
        send_frame(40, 0, 0, 8'h66, 1);           // R8 consumer write lands with commit
        check(buf_empty == 1'b1, "R8 empty with same-cycle commit", int'(buf_empty), 1);
        check(int'(wr_ofs) == 212, "R4 offset after concurrent commit", int'(wr_ofs), 212);

        repeat (10) @(negedge clk);
        check(sb.size() == 0, "R4 all frames resolved", sb.size(), 0);
        check(bad_be == 0, "R10 byte enables contiguous", bad_be, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule